// File: doc/BRIEF.md
# Start-stop link delay timer

The block times how long a marker code group takes to cross a serial link running 8B/10B code groups. The transmit path sends a two-byte word every word-clock cycle. At rest that word is the idle pair: comma control byte 0xBC (K28.5) followed by data byte 0x50 (D16.2). When a measurement starts, one idle pair is replaced by a marker pair: control byte 0xF7 (K23.7) followed by a configurable data byte. At the same time a coarse counter starts.

The receive path looks at the word-aligned stream. When the marker pair arrives, the counter stops and the aligner's current slip position is captured. The result is the coarse count times one word period, plus the slip position times one bit time, reported in picoseconds. With a 3.125 Gb/s link, a word period is 6400 ps and a bit time is 320 ps.

The method is only valid when the receive word clock is recovered from the transmitter, so that both ends share one time base with a fixed offset. The whole block therefore runs on a single clock.

Top module: `pdt_timer`

## Requirements
- R1: After reset the block is not busy, `done_o` and `timeout_o` are 0, `count_o` and `delay_ps_o` are 0, and the transmit word is the idle pair.
- R2: When no start is requested, every transmit word is the idle pair: `tx_data_o` = 16'hBC50 and `tx_k_o` = 2'b10. Bit 15..8 is the first byte and `tx_k_o[1]` flags it as a control byte.
- R3: When `start_i` is sampled high at a clock edge, the word after that edge is the marker pair for exactly one cycle: `tx_data_o` = {8'hF7, MARK_DATA} and `tx_k_o` = 2'b10. The idle pair follows.
- R4: The start edge clears the count and sets `busy_o`. If the marker is sampled on the Nth rising edge after the start edge, `count_o` = N-1.
- R5: A received word stops the count only if all three hold: `rx_k_i` = 2'b10, `rx_data_i[15:8]` = 8'hF7, and `rx_data_i[7:0]` = MARK_DATA. Any other word, such as a marker with the wrong data byte or wrong control flags, has no effect.
- R6: `done_o` is a one-cycle pulse in the cycle after the stop edge, and `busy_o` is low in that same cycle.
- R7: While the block is not busy, markers and slip changes leave `count_o` and `delay_ps_o` unchanged and raise no `done_o`.
- R8: `slip_i` is captured at the stop edge, and `delay_ps_o` = `count_o`*WORD_PS + slip*UI_PS.
- R9: If the count is at its maximum and an edge sees no marker, `timeout_o` rises, `busy_o` falls, `count_o` holds the maximum, and no `done_o` is raised.
- R10: A start while busy or after a timeout restarts the count from 0 and clears `timeout_o`.
- R11: A result that does not fit in RES_W bits is reported as all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock, shared by both link ends |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a new measurement |
| rx_data_i | input | 16 | Aligned received word, first byte in bits 15..8 |
| rx_k_i | input | 2 | Control flags of the received bytes |
| slip_i | input | SLIP_W | Current bit-slip position of the word aligner |
| tx_data_o | output | 16 | Transmit word, first byte in bits 15..8 |
| tx_k_o | output | 2 | Control flags of the transmit bytes |
| busy_o | output | 1 | Measurement in progress |
| done_o | output | 1 | One-cycle pulse when a result is valid |
| timeout_o | output | 1 | Counter saturated before a marker arrived |
| count_o | output | CNT_W | Coarse delay in word periods |
| delay_ps_o | output | RES_W | Combined delay in picoseconds |

## Verification
The bench builds the block with CNT_W = 8 and RES_W = 20, keeping the default WORD_PS = 6400 and UI_PS = 320. The 8-bit counter saturates after 255 counts, so the timeout path is exercised within a few hundred cycles. The 20-bit result overflows from a count of about 164 upward, so the saturating result is exercised by ordinary measurements near the top of the count range. Random delays and slip values cover both the in-range and the clamped results.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  localparam logic [7:0] CODE_IDLE_K = 8'hBC;  // K28.5
  localparam logic [7:0] CODE_IDLE_D = 8'h50;  // D16.2
  localparam logic [7:0] CODE_MARK_K = 8'hF7;  // K23.7
  localparam logic [1:0] FLAGS_PAIR  = 2'b10;  // first byte control, second data
endpackage

// File: rtl/pdt_tx_gen.sv
module pdt_tx_gen
  import pdt_pkg::*;
#(
  parameter logic [7:0] MARK_DATA = 8'hA5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  output logic [15:0] tx_data_o,
  output logic [1:0]  tx_k_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_data_o <= {CODE_IDLE_K, CODE_IDLE_D};
      tx_k_o    <= FLAGS_PAIR;
    end else begin
      tx_data_o <= start_i ? {CODE_MARK_K, MARK_DATA} : {CODE_IDLE_K, CODE_IDLE_D};
      tx_k_o    <= FLAGS_PAIR;
    end
  end

  // R3
  marker_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (tx_k_o == FLAGS_PAIR) && (tx_data_o[15:8] == CODE_MARK_K));
  // R2
  idle_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> tx_data_o == {CODE_IDLE_K, CODE_IDLE_D});
endmodule

// File: rtl/pdt_coarse_cnt.sv
module pdt_coarse_cnt #(
  parameter int CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             hit_i,
  output logic             stop_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             timeout_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assign stop_o = busy_o && hit_i && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o     <= '0;
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
    end else if (start_i) begin
      cnt_o     <= '0;
      busy_o    <= 1'b1;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
    end else if (busy_o) begin
      if (hit_i) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
      end else if (cnt_o == CNT_MAX) begin
        busy_o    <= 1'b0;
        timeout_o <= 1'b1;
        done_o    <= 1'b0;
      end else begin
        cnt_o  <= cnt_o + 1'b1;
        done_o <= 1'b0;
      end
    end else begin
      done_o <= 1'b0;
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !hit_i && !start_i && cnt_o == CNT_MAX)
      |=> (timeout_o && !busy_o && !done_o && cnt_o == CNT_MAX));
  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(cnt_o) && !done_o);
  // R6
  done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !timeout_o);
endmodule

// File: rtl/pdt_result.sv
module pdt_result #(
  parameter int CNT_W   = 20,
  parameter int SLIP_W  = 5,
  parameter int RES_W   = 32,
  parameter int WORD_PS = 6400,
  parameter int UI_PS   = 320
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stop_i,
  input  logic [SLIP_W-1:0] slip_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [RES_W-1:0]  delay_ps_o
);
  localparam int FULL_W = CNT_W + $clog2(WORD_PS + 1) + 2;

  logic [SLIP_W-1:0] slip_q;
  logic [FULL_W-1:0] full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     slip_q <= '0;
    else if (stop_i) slip_q <= slip_i;
  end

  assign full = FULL_W'(cnt_i) * FULL_W'(WORD_PS) + FULL_W'(slip_q) * FULL_W'(UI_PS);

  generate
    if (FULL_W > RES_W) begin : g_clamp
      assign delay_ps_o = (|full[FULL_W-1:RES_W]) ? '1 : full[RES_W-1:0];
    end else begin : g_plain
      assign delay_ps_o = RES_W'(full);
    end
  endgenerate

  // R8
  slip_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_i |=> $stable(slip_q));
endmodule

// File: rtl/pdt_timer.sv
module pdt_timer
  import pdt_pkg::*;
#(
  parameter int         CNT_W     = 20,
  parameter int         SLIP_W    = 5,
  parameter int         RES_W     = 32,
  parameter int         WORD_PS   = 6400,
  parameter int         UI_PS     = 320,
  parameter logic [7:0] MARK_DATA = 8'hA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [15:0]       rx_data_i,
  input  logic [1:0]        rx_k_i,
  input  logic [SLIP_W-1:0] slip_i,
  output logic [15:0]       tx_data_o,
  output logic [1:0]        tx_k_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [RES_W-1:0]  delay_ps_o
);
  logic hit, stop;

  // full pair match: control marker byte plus the expected data byte
  assign hit = (rx_k_i == FLAGS_PAIR) && (rx_data_i == {CODE_MARK_K, MARK_DATA});

  pdt_tx_gen #(.MARK_DATA(MARK_DATA)) u_tx (
    .clk_i, .rst_ni, .start_i, .tx_data_o, .tx_k_o
  );

  pdt_coarse_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .start_i, .hit_i(hit), .stop_o(stop),
    .busy_o, .done_o, .timeout_o, .cnt_o(count_o)
  );

  pdt_result #(
    .CNT_W(CNT_W), .SLIP_W(SLIP_W), .RES_W(RES_W), .WORD_PS(WORD_PS), .UI_PS(UI_PS)
  ) u_res (
    .clk_i, .rst_ni, .stop_i(stop), .slip_i, .cnt_i(count_o), .delay_ps_o
  );

  // R4
  start_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o && count_o == '0 && !timeout_o);
  // R5
  stop_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !start_i && !hit) |=> !done_o);
endmodule

// File: tb/pdt_timer_tb.sv
module pdt_timer_tb_top;
  localparam int CNT_W = 8;
  localparam int RES_W = 20;
  localparam int SLIP_W = 5;
  localparam logic [7:0] MD = 8'hA5;

  logic clk = 0, rst_n = 0, start = 0;
  logic [15:0] rx_data = 16'hBC50;
  logic [1:0] rx_k = 2'b10;
  logic [SLIP_W-1:0] slip = '0;
  logic [15:0] tx_data;
  logic [1:0] tx_k;
  logic busy, done, tmo;
  logic [CNT_W-1:0] cnt;
  logic [RES_W-1:0] dly;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  pdt_timer #(.CNT_W(CNT_W), .RES_W(RES_W), .SLIP_W(SLIP_W), .MARK_DATA(MD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rx_data_i(rx_data), .rx_k_i(rx_k),
    .slip_i(slip), .tx_data_o(tx_data), .tx_k_o(tx_k), .busy_o(busy), .done_o(done),
    .timeout_o(tmo), .count_o(cnt), .delay_ps_o(dly)
  );

  function automatic longint exp_delay(int n, int s);
    longint v = longint'(n) * 6400 + longint'(s) * 320;
    return (v > 64'd1048575) ? 64'd1048575 : v;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  // marker sampled on edge n+1 after the start edge; slip s presented then
  task automatic measure(int n, int s);
    do_start();
    chk("R3 marker word", {tx_k, tx_data}, {2'b10, 8'hF7, MD});
    chk("R4 busy", busy, 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) chk("R2 idle after marker", {tx_k, tx_data}, {2'b10, 16'hBC50});
    end
    rx_data = {8'hF7, MD}; rx_k = 2'b10; slip = SLIP_W'(s);
    @(negedge clk);
    rx_data = 16'hBC50; slip = SLIP_W'($urandom);
    chk("R6 done", done, 1);
    chk("R6 busy low", busy, 0);
    chk("R4 count", cnt, n);
    chk("R8/R11 delay", dly, exp_delay(n, s));
    @(negedge clk);
    chk("R6 single pulse", done, 0);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #20;
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 timeout", tmo, 0);
    chk("R1 count", cnt, 0);
    chk("R1 delay", dly, 0);
    chk("R1 tx idle", {tx_k, tx_data}, {2'b10, 16'hBC50});
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R2 idle", {tx_k, tx_data}, {2'b10, 16'hBC50});

    measure(0, 0);
    measure(1, 1);
    measure(3, 3);
    measure(163, 0);
    measure(163, 31);  // R11 clamp
    measure(200, 5);   // R11 clamp

    // R7: marker while idle is ignored
    begin
      logic [CNT_W-1:0] c0; logic [RES_W-1:0] d0;
      c0 = cnt; d0 = dly;
      rx_data = {8'hF7, MD}; slip = 5'd17;
      @(negedge clk); rx_data = 16'hBC50;
      chk("R7 no done", done, 0);
      @(negedge clk);
      chk("R7 count held", cnt, c0);
      chk("R7 delay held", dly, d0);
    end

    // R5: look-alike words do not stop
    do_start();
    rx_data = {8'hF7, 8'h00}; @(negedge clk);
    rx_data = {8'hF7, MD}; rx_k = 2'b11; @(negedge clk);
    rx_k = 2'b00; @(negedge clk);
    rx_data = 16'hBC50; rx_k = 2'b10; @(negedge clk);
    chk("R5 still busy", busy, 1);
    chk("R5 no done", done, 0);
    chk("R5 counting", cnt, 4);
    rx_data = {8'hF7, MD}; slip = 5'd2; @(negedge clk);
    rx_data = 16'hBC50;
    chk("R5 real marker", cnt, 4);
    chk("R5 done", done, 1);

    // R10: restart while busy
    do_start();
    repeat (10) @(negedge clk);
    measure(4, 7);

    // R9: timeout
    do_start();
    repeat (255) @(negedge clk);
    chk("R9 busy at max", busy, 1);
    chk("R9 count max", cnt, 255);
    @(negedge clk);
    chk("R9 timeout", tmo, 1);
    chk("R9 busy low", busy, 0);
    chk("R9 no done", done, 0);
    @(negedge clk);
    chk("R9 count held", cnt, 255);

    // R10: start clears timeout
    do_start();
    chk("R10 timeout cleared", tmo, 0);
    chk("R10 count cleared", cnt, 0);
    @(negedge clk);
    rx_data = {8'hF7, MD}; slip = 5'd9; @(negedge clk);
    rx_data = 16'hBC50;
    chk("R10 restart count", cnt, 1);

    for (int t = 0; t < 25; t++) begin
      int n, s;
      n = int'($urandom % 240);
      s = int'($urandom % 32);
      measure(n, s);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule